// File: doc/BRIEF.md
# Video Timing Generator with Prefetch

This block is a display timing engine. From a programmed mode it produces horizontal and vertical sync, a data-enable window, a pixel output with border and underflow colours, and a one-cycle fetch-start pulse. The mode is given as active size, sync start, sync end and total for each axis, plus requested sync polarities. It also takes an interface-type select, a wide-bus flag and a worst-case prefetch latency in lines. The engine derives the porch and pulse lengths. It adjusts them for the selected interface type. It then places the fetch-start point inside the vertical front porch, so that the upstream pixel fetch can begin early enough to cover the worst-case latency.

Each line is laid out as sync pulse, back porch, active, front porch. Each frame is laid out as sync lines, back-porch lines, active lines, front-porch lines. A new configuration is sampled only when a frame starts. When the engine is enabled from idle, the first frame starts as soon as the registered enable is seen. Clearing the enable lets the current frame finish. The engine reports a 1-based line number and a frame count. During the prefetch window the frame count looks ahead by one, because the next frame is already being fetched.

Top module: `vid_timing_gen`

## Requirements
- R1: A mode is rejected if any of these holds on either axis: total < sync_end, sync_start < active, or sync_end < sync_start. A rejected mode keeps the engine idle: running and de stay 0 and no frame starts.
- R2: Within a line, hsync is active for (sync_end − sync_start) cycles starting at the line's first cycle. It is followed by back porch (total − sync_end), active (de high for the active width) and front porch (sync_start − active). The line period is the sum of these four parts.
- R3: Within a frame, vsync is active for (sync_end − sync_start) lines starting at the frame's first line. It is followed by the back-porch lines, the active lines and the front-porch lines. de is high only on active columns of active lines.
- R4: The polarity inputs h_neg and v_neg set 1 for an active-low sync and 0 for active-high. ifc_sel = 1 (DSI) forces both syncs to active-high regardless of h_neg and v_neg. Outside the sync pulse each sync sits at its inactive level.
- R5: ifc_sel = 2 (DP) moves the front porch into the back porch on both axes. The front porch becomes zero, so the active area ends on the last cycle of the frame.
- R6: With ifc_sel = 2 and wide_bus = 1, the active width, horizontal back porch, horizontal front porch and hsync width are each halved (shifted right by one).
- R7: Let sof = vertical back porch + vsync width. The prefetch line count is computed as follows. If sof ≥ wc_lines, the count is 0 and prefetch is off. Otherwise, if the vertical front porch is below (wc_lines − sof), the whole vertical front porch is used. Otherwise the count is exactly wc_lines − sof.
- R8: When the prefetch count n is nonzero, fetch_start pulses for one cycle. It pulses when a pixel counter, equal to 1 on the frame's first cycle, reaches (vtotal − n) × htotal + 1. htotal and vtotal are the rebuilt totals after the R5 and R6 adjustments.
- R9: While prefetch is on and the engine runs, frame_cnt reports the started-frame count plus one when line_cnt > (vtotal − vertical front porch) and line_cnt ≤ vtotal. Otherwise it reports the started-frame count, which is 0 after reset.
- R10: pix_out is 0 outside de. Inside de it is pix_in while pix_valid is high and underrun is clear. A de cycle with pix_valid low sets underrun, which stays set until the next frame starts. While underrun is set, or pix_valid is low, pix_out inside de is all ones (0xFF).
- R11: en is registered. Mode inputs changed during a frame take effect only at the next frame start. Clearing en stops output only after the current frame's last cycle. After reset the engine is idle with de, syncs and fetch_start low.
- R12: vs_start is high exactly on the first cycle of each frame. line_cnt is the 1-based line number within the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable (registered inside) |
| ifc_sel | input | 2 | Interface type: 0 other, 1 DSI, 2 DP |
| wide_bus | input | 1 | Wide-bus mode (halves horizontal timing for DP) |
| h_act | input | CW | Active width |
| h_ss | input | CW | Horizontal sync start |
| h_se | input | CW | Horizontal sync end |
| h_tot | input | CW | Horizontal total |
| v_act | input | CW | Active height |
| v_ss | input | CW | Vertical sync start |
| v_se | input | CW | Vertical sync end |
| v_tot | input | CW | Vertical total |
| h_neg | input | 1 | Requested active-low hsync |
| v_neg | input | 1 | Requested active-low vsync |
| wc_lines | input | CW | Worst-case prefetch latency in lines |
| pix_valid | input | 1 | Upstream pixel present |
| pix_in | input | DW | Upstream pixel value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | DW | Output pixel (border, data or underflow colour) |
| fetch_start | output | 1 | One-cycle prefetch start pulse |
| vs_start | output | 1 | One-cycle frame start pulse |
| underrun | output | 1 | Sticky underrun flag for the current frame |
| running | output | 1 | Engine is producing a frame |
| line_cnt | output | CW | 1-based current line, 0 when idle |
| frame_cnt | output | CW | Frame count with prefetch look-ahead |

## Verification
The assertions check every cycle that de never overlaps the hsync pulse. They also check that fetch_start is a single cycle outside de, and that vs_start coincides with active vsync. They check that a running frame is never cut short, that a rejected mode never starts the engine, and that underrun holds until the next frame start. The bench scenarios are needed for anything that depends on exact positions. That covers the first de cycle after the DP porch shift and the wide-bus halving, and the fetch-start cycle under each of the three prefetch-count cases. It also covers the frame-count look-ahead boundary, the polarity override, and the one-frame delay before a mode change or a disable takes hold.

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter int CW = 16,
  parameter int PW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    ifc_sel,
  input  logic          wide_bus,
  input  logic [CW-1:0] h_act,
  input  logic [CW-1:0] h_ss,
  input  logic [CW-1:0] h_se,
  input  logic [CW-1:0] h_tot,
  input  logic [CW-1:0] v_act,
  input  logic [CW-1:0] v_ss,
  input  logic [CW-1:0] v_se,
  input  logic [CW-1:0] v_tot,
  input  logic          h_neg,
  input  logic          v_neg,
  input  logic [CW-1:0] wc_lines,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [DW-1:0] pix_out,
  output logic          fetch_start,
  output logic          vs_start,
  output logic          underrun,
  output logic          running,
  output logic [CW-1:0] line_cnt,
  output logic [CW-1:0] frame_cnt
);
  localparam logic [DW-1:0] UFLOW_CLR  = {DW{1'b1}};
  localparam logic [DW-1:0] BORDER_CLR = '0;
  localparam logic [1:0]    IFC_DSI    = 2'd1;
  localparam logic [1:0]    IFC_DP     = 2'd2;

  // mode derivation from the live inputs
  logic is_dp, half;
  logic [CW-1:0] hfp0, hsw0, hbp0, vfp0, vsw0, vbp0;
  logic [CW-1:0] hsw_n, hbp_n, hact_n, hfp_n, htot_n;
  logic [CW-1:0] vbp_n, vfp_n, vtot_n, pf_n, need;
  logic [CW:0]   sof;
  logic [PW-1:0] cmp_n;
  logic          cfg_ok;

  assign is_dp  = (ifc_sel == IFC_DP);
  assign half   = is_dp && wide_bus;
  assign hfp0   = h_ss - h_act;
  assign hsw0   = h_se - h_ss;
  assign hbp0   = h_tot - h_se;
  assign vfp0   = v_ss - v_act;
  assign vsw0   = v_se - v_ss;
  assign vbp0   = v_tot - v_se;
  assign hsw_n  = half ? hsw0 >> 1 : hsw0;
  assign hact_n = half ? h_act >> 1 : h_act;
  assign hbp_n  = is_dp ? (half ? (hbp0 + hfp0) >> 1 : hbp0 + hfp0) : hbp0;
  assign hfp_n  = is_dp ? '0 : hfp0;
  assign vbp_n  = is_dp ? vbp0 + vfp0 : vbp0;
  assign vfp_n  = is_dp ? '0 : vfp0;
  assign htot_n = hsw_n + hbp_n + hact_n + hfp_n;
  assign vtot_n = vsw0 + vbp_n + v_act + vfp_n;

  assign cfg_ok = !(h_tot < h_se || h_ss < h_act || h_se < h_ss ||
                    v_tot < v_se || v_ss < v_act || v_se < v_ss) &&
                  htot_n != '0 && vtot_n != '0;

  assign sof   = {1'b0, vbp_n} + {1'b0, vsw0};
  assign need  = wc_lines - sof[CW-1:0];
  assign pf_n  = (sof >= {1'b0, wc_lines}) ? '0 : (vfp_n < need) ? vfp_n : need;
  assign cmp_n = {{(PW-CW){1'b0}}, vtot_n - pf_n} * {{(PW-CW){1'b0}}, htot_n} + PW'(1);

  // active configuration and counters
  logic          en_q, run_q, und_q, pf_en_q, hpol_q, vpol_q;
  logic [CW-1:0] hcnt, vcnt, fcnt;
  logic [CW-1:0] hsw_q, hde_s_q, hde_e_q, htot_q;
  logic [CW-1:0] vsw_q, vde_s_q, vde_e_q, vtot_q, vfp_q;
  logic [PW-1:0] pcnt, cmp_q;
  logic          h_end, frame_end, load, h_on, v_on;

  assign h_end     = (hcnt == htot_q - CW'(1));
  assign frame_end = run_q && h_end && (vcnt == vtot_q - CW'(1));
  assign load      = en_q && cfg_ok && (!run_q || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; run_q <= 1'b0; und_q <= 1'b0; pf_en_q <= 1'b0;
      hpol_q <= 1'b0; vpol_q <= 1'b0;
      hcnt <= '0; vcnt <= '0; fcnt <= '0; pcnt <= '0; cmp_q <= '0;
      hsw_q <= '0; hde_s_q <= '0; hde_e_q <= '0; htot_q <= '1;
      vsw_q <= '0; vde_s_q <= '0; vde_e_q <= '0; vtot_q <= '1; vfp_q <= '0;
    end else begin
      en_q <= en;
      if (load) begin
        run_q   <= 1'b1;
        hcnt    <= '0;
        vcnt    <= '0;
        pcnt    <= PW'(1);
        fcnt    <= fcnt + CW'(1);
        hsw_q   <= hsw_n;
        hde_s_q <= hsw_n + hbp_n;
        hde_e_q <= hsw_n + hbp_n + hact_n;
        htot_q  <= htot_n;
        vsw_q   <= vsw0;
        vde_s_q <= vsw0 + vbp_n;
        vde_e_q <= vsw0 + vbp_n + v_act;
        vtot_q  <= vtot_n;
        vfp_q   <= vfp_n;
        pf_en_q <= (pf_n != '0);
        cmp_q   <= cmp_n;
        hpol_q  <= (ifc_sel == IFC_DSI) ? 1'b0 : h_neg;
        vpol_q  <= (ifc_sel == IFC_DSI) ? 1'b0 : v_neg;
      end else if (frame_end) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        hcnt <= h_end ? '0 : hcnt + CW'(1);
        vcnt <= h_end ? vcnt + CW'(1) : vcnt;
        pcnt <= pcnt + PW'(1);
      end
      if (load)                    und_q <= 1'b0;
      else if (de && !pix_valid)   und_q <= 1'b1;
    end
  end

  assign h_on        = run_q && (hcnt < hsw_q);
  assign v_on        = run_q && (vcnt < vsw_q);
  assign hsync       = h_on ^ hpol_q;
  assign vsync       = v_on ^ vpol_q;
  assign de          = run_q && hcnt >= hde_s_q && hcnt < hde_e_q &&
                       vcnt >= vde_s_q && vcnt < vde_e_q;
  assign vs_start    = run_q && hcnt == '0 && vcnt == '0;
  assign fetch_start = run_q && pf_en_q && (pcnt == cmp_q);
  assign line_cnt    = run_q ? vcnt + CW'(1) : '0;
  assign frame_cnt   = (pf_en_q && run_q && line_cnt > vtot_q - vfp_q &&
                        line_cnt <= vtot_q) ? fcnt + CW'(1) : fcnt;
  assign pix_out     = !de ? BORDER_CLR : (und_q || !pix_valid) ? UFLOW_CLR : pix_in;
  assign underrun    = und_q;
  assign running     = run_q;

  a_r2_de_outside_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !h_on);
  a_r8_fetch_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> !de);
  a_r8_fetch_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);
  a_r12_frame_start_in_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_start && vsw_q != '0) |-> (vsync != vpol_q));
  a_r11_frame_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !frame_end) |=> run_q);
  a_r1_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cfg_ok) |=> !run_q);
  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (und_q && !load) |=> und_q);
endmodule

// File: tb/tb_vid_timing_gen.sv
module tb_vid_timing_gen;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [1:0] ifc_sel = 2'd0;
  logic wide_bus = 1'b0, h_neg = 1'b0, v_neg = 1'b0, pix_valid = 1'b1;
  logic [15:0] h_act = 4, h_ss = 6, h_se = 8, h_tot = 11;
  logic [15:0] v_act = 3, v_ss = 4, v_se = 5, v_tot = 7, wc_lines = 3;
  logic [7:0] pix_in = 8'h5A, pix_out;
  logic hsync, vsync, de, fetch_start, vs_start, underrun, running;
  logic [15:0] line_cnt, frame_cnt;

  always #10 clk = ~clk;

  vid_timing_gen dut (.clk, .rst_n, .en, .ifc_sel, .wide_bus, .h_act, .h_ss, .h_se,
    .h_tot, .v_act, .v_ss, .v_se, .v_tot, .h_neg, .v_neg, .wc_lines, .pix_valid,
    .pix_in, .hsync, .vsync, .de, .pix_out, .fetch_start, .vs_start, .underrun,
    .running, .line_cnt, .frame_cnt);

  int n_chk = 0, n_err = 0;
  logic hs_a[256], vs_a[256], de_a[256], fs_a[256];
  logic [15:0] fc_a[256], ln_a[256];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_vs();
    bit ok = 0;
    for (int i = 0; i < 2000 && !ok; i++) begin
      @(negedge clk);
      if (vs_start) ok = 1;
    end
    chk("R12 frame start seen", ok, 1);
  endtask

  task automatic cap(input int len);
    for (int i = 0; i < len; i++) begin
      hs_a[i] = hsync; vs_a[i] = vsync; de_a[i] = de; fs_a[i] = fetch_start;
      fc_a[i] = frame_cnt; ln_a[i] = line_cnt;
      @(negedge clk);
    end
  endtask

  function automatic int count_de(input int len);
    int c = 0;
    for (int i = 0; i < len; i++) c += de_a[i];
    return c;
  endfunction

  function automatic int first_de(input int len);
    for (int i = 0; i < len; i++) if (de_a[i]) return i;
    return -1;
  endfunction

  function automatic int fetch_idx(input int len);
    for (int i = 0; i < len; i++) if (fs_a[i]) return i;
    return -1;
  endfunction

  function automatic int count_fs(input int len);
    int c = 0;
    for (int i = 0; i < len; i++) c += fs_a[i];
    return c;
  endfunction

  task automatic t_invalid();
    h_ss = 3; en = 1;
    repeat (200) begin @(negedge clk); if (running) chk("R1 horizontal reject idle", running, 0); end
    chk("R1 horizontal reject idle", running, 0);
    h_ss = 6; v_se = 3;
    repeat (200) begin @(negedge clk); if (de) chk("R1 vertical reject no de", de, 0); end
    chk("R1 vertical reject idle", running, 0);
    v_se = 5;
    wait_vs();
    chk("R1 valid mode starts", running, 1);
  endtask

  task automatic t_basic();
    wait_vs(); cap(77);
    chk("R12 vs_start next frame after 77", vs_start, 1);
    chk("R12 line 1", ln_a[0], 1);
    chk("R12 line 2", ln_a[11], 2);
    chk("R2 hsync at line start", hs_a[0], 1);
    chk("R2 hsync end", {hs_a[1], hs_a[2]}, 2'b10);
    chk("R3 vsync first line", vs_a[10], 1);
    chk("R3 vsync ends", vs_a[11], 0);
    chk("R3 de count", count_de(77), 12);
    chk("R2 first de", first_de(77), 38);
    chk("R3 last de", {de_a[63], de_a[64]}, 2'b10);
    chk("R7 prefetch off when sof>=wc", count_fs(77), 0);
    chk("R9 no lookahead without prefetch", fc_a[70], fc_a[0]);
  endtask

  task automatic t_prefetch();
    wc_lines = 5; wait_vs(); cap(77);
    chk("R7 whole vfp used", count_fs(77), 1);
    chk("R8 fetch position vfp case", fetch_idx(77), 66);
    chk("R9 before window", fc_a[65], fc_a[0]);
    chk("R9 in window", fc_a[66], fc_a[0] + 16'd1);
    v_ss = 6; v_se = 7; v_tot = 9;
    wait_vs(); cap(99);
    chk("R7 exact difference", fetch_idx(99), 77);
    chk("R9 before window mode2", fc_a[65], fc_a[0]);
    chk("R9 in window mode2", fc_a[66], fc_a[0] + 16'd1);
    wc_lines = 20;
    wait_vs(); cap(99);
    chk("R8 large wc uses whole vfp", fetch_idx(99), 66);
    v_ss = 4; v_se = 5; v_tot = 7; wc_lines = 3;
    wait_vs();
  endtask

  task automatic t_polarity();
    h_neg = 1; v_neg = 1;
    wait_vs(); cap(77);
    chk("R4 active-low hsync pulse", hs_a[0], 0);
    chk("R4 active-low hsync idle", hs_a[5], 1);
    chk("R4 active-low vsync", {vs_a[0], vs_a[20]}, 2'b01);
    ifc_sel = 2'd1;
    wait_vs(); cap(77);
    chk("R4 DSI forces high hsync", {hs_a[0], hs_a[5]}, 2'b10);
    chk("R4 DSI forces high vsync", {vs_a[0], vs_a[20]}, 2'b10);
    h_neg = 0; v_neg = 0; ifc_sel = 2'd0;
    wait_vs();
  endtask

  task automatic t_dp();
    ifc_sel = 2'd2;
    wait_vs(); cap(77);
    chk("R5 DP first de", first_de(77), 51);
    chk("R5 DP de ends at frame end", de_a[76], 1);
    chk("R5 DP de count", count_de(77), 12);
    wide_bus = 1;
    wait_vs(); cap(35);
    chk("R6 wide frame length", vs_start, 1);
    chk("R6 wide first de", first_de(35), 23);
    chk("R6 wide de count", count_de(35), 6);
    chk("R6 wide hsync width", {hs_a[0], hs_a[1]}, 2'b10);
    wide_bus = 0; ifc_sel = 2'd0;
    wait_vs();
  endtask

  task automatic t_underrun();
    wait_vs();
    chk("R10 border colour", pix_out, 0);
    repeat (38) @(negedge clk);
    chk("R10 data passes", pix_out, 8'h5A);
    chk("R10 no underrun yet", underrun, 0);
    pix_valid = 0; #1;
    chk("R10 missing pixel fill", pix_out, 8'hFF);
    @(negedge clk); pix_valid = 1; #1;
    chk("R10 underrun set", underrun, 1);
    chk("R10 fill while set", pix_out, 8'hFF);
    wait_vs();
    chk("R10 cleared at frame start", underrun, 0);
    repeat (38) @(negedge clk);
    chk("R10 data after clear", pix_out, 8'h5A);
  endtask

  task automatic t_cfg_change();
    int early = 0;
    wait_vs();
    for (int i = 1; i < 77; i++) begin
      @(negedge clk);
      if (i == 5) h_tot = 13;
      early += vs_start;
    end
    @(negedge clk);
    chk("R11 change waits for frame end", early, 0);
    chk("R11 old frame length kept", vs_start, 1);
    repeat (91) @(negedge clk);
    chk("R11 new length applied", vs_start, 1);
    h_tot = 11;
    wait_vs();
  endtask

  task automatic t_disable();
    int drops = 0;
    wait_vs();
    for (int i = 1; i < 77; i++) begin
      @(negedge clk);
      if (i == 10) en = 0;
      if (!running) drops++;
    end
    chk("R11 frame completes after disable", drops, 0);
    @(negedge clk);
    chk("R11 stopped after frame", running, 0);
    repeat (150) @(negedge clk);
    chk("R11 stays idle", {running, de}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset idle", running, 0);
    chk("R11 reset de/syncs", {de, hsync, vsync, fetch_start}, 4'b0000);
    chk("R9 reset frame count", frame_cnt, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_invalid();
    t_basic();
    t_prefetch();
    t_polarity();
    t_dp();
    t_underrun();
    t_cfg_change();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule